// File: doc/BRIEF.md
# AC-link Input Frame Serializer

This block is the codec end of a serial audio link. It turns parallel status and sample data into the bit stream that travels back to the link controller. The controller owns frame timing. It raises SYNC in step with the rising edge of the bit clock. The block samples SYNC on the falling edge and treats a low-to-high change there as the start of a new frame. On the rising edge that follows, it launches the first frame bit. It then sends one bit per rising edge, so the controller can capture each bit on the next falling edge.

A frame is 256 bits, sent MSB first:

- a 16-bit tag slot that carries a ready flag and one valid flag per data slot;
- a 20-bit status-address slot that echoes a register index and carries slot-request bits;
- eleven 20-bit data slots.

The block forces every position that carries no valid content to zero. At each frame start it latches the whole frame and pulses `load_ack`, so the source can present the next frame's contents.

Top module: `acl_infrm_gen`

## Requirements
- R1: A 0-to-1 change of `sync` between two falling edges of `bit_clk` starts a frame. On the next rising edge, `sdata_out` presents frame bit 255 (tag bit 15), and `load_ack` is high for exactly that one cycle.
- R2: A frame is 256 bits, one bit per rising edge, MSB first. The order is tag slot (bits 255:240), slot 1 (bits 239:220), then slots 2 to 12, 20 bits each, with slot s ending at bit 240-20*s.
- R3: In the tag slot, bit 15 is the ready flag. Bits 14:3 are `slot_tags[11:0]`, where `slot_tags[11]` is slot 1 and `slot_tags[0]` is slot 12. Bits 2:0 are 0.
- R4: While `codec_ready` is low at frame start, the whole frame is sent as zeros, including the ready flag and all tags.
- R5: Slot 1, when its tag is set, is sent as {0, `reg_index[6:0]`, `slot_req[9:0]`, 00}. Slot-request bit n sits at slot bit n+2, so line 1 (slot bit 9) is `slot_req[7]` and line 2 (slot bit 4) is `slot_req[2]`.
- R6: Slot s (2 to 12), when its tag is set, carries `slot_data[(s-2)*20 +: 20]` MSB first. A slot whose tag is clear is sent as 20 zeros.
- R7: Frame contents are captured at frame start. Input changes during a frame do not alter the bits still to be sent.
- R8: After the 256th bit, `sdata_out` is 0 until the next frame start. A `sync` held high does not start another frame.
- R9: A new 0-to-1 `sync` change during a frame abandons the current frame and starts a fresh one, as in R1.
- R10: While `rst_n` is low, `sdata_out` and `load_ack` are 0 and no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame sync from controller |
| codec_ready | input | 1 | Codec ready flag for the tag slot |
| slot_tags | input | 12 | Valid flags, bit 11 = slot 1 ... bit 0 = slot 12 |
| reg_index | input | 7 | Register index echoed in slot 1 |
| slot_req | input | 10 | Slot-request bits for slot 1 bits 11:2 |
| slot_data | input | 220 | Data for slots 2..12, 20 bits each |
| sdata_out | output | 1 | Serial frame output |
| load_ack | output | 1 | One-cycle pulse when frame contents are captured |

## Verification
The bench compares whole captured frames against a model built from the requirements. It targets four corner cases:

- **Sparse tag patterns and a set of slot-request bits.** A design with a slot off by one position, or that leaks data from an untagged slot, would show stray ones.
- **A frame sent with the ready flag low.** This catches a design that still emits tags.
- **Inputs rewritten mid-frame.** This exposes a design that reads live inputs instead of a captured copy.
- **SYNC held high through and past a frame, and a second SYNC edge mid-frame.** A design with level-sensitive start detection would emit repeated frames, and one that ignores a restart would finish the stale frame.

// File: rtl/acl_infrm_gen.sv
module acl_infrm_gen (
  input  logic         bit_clk,
  input  logic         rst_n,
  input  logic         sync,
  input  logic         codec_ready,
  input  logic [11:0]  slot_tags,
  input  logic [6:0]   reg_index,
  input  logic [9:0]   slot_req,
  input  logic [219:0] slot_data,
  output logic         sdata_out,
  output logic         load_ack
);
  localparam int FRAME_W = 256;
  localparam int SLOT_W  = 20;
  localparam int TAG_W   = 16;
  localparam int NSLOT   = 12;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic               sync_s, sync_prev;
  logic               start_pend;
  logic [FRAME_W-1:0] frame_next, shreg;
  logic [CNT_W-1:0]   cnt;

  always_ff @(negedge bit_clk or negedge rst_n)
    if (!rst_n) begin
      sync_s    <= 1'b0;
      sync_prev <= 1'b0;
    end else begin
      sync_s    <= sync;
      sync_prev <= sync_s;
    end

  assign start_pend = sync_s & ~sync_prev;

  always_comb begin
    frame_next = '0;
    if (codec_ready) begin
      frame_next[FRAME_W-1]              = 1'b1;
      frame_next[FRAME_W-2 -: NSLOT]     = slot_tags;
      if (slot_tags[NSLOT-1])
        frame_next[FRAME_W-TAG_W-1 -: SLOT_W] = {1'b0, reg_index, slot_req, 2'b00};
      for (int s = 2; s <= NSLOT; s++)
        if (slot_tags[NSLOT-s])
          frame_next[FRAME_W-TAG_W-1-(s-1)*SLOT_W -: SLOT_W] = slot_data[(s-2)*SLOT_W +: SLOT_W];
    end
  end

  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n) begin
      shreg     <= '0;
      cnt       <= '0;
      sdata_out <= 1'b0;
      load_ack  <= 1'b0;
    end else begin
      load_ack <= start_pend;
      if (start_pend) begin
        sdata_out <= frame_next[FRAME_W-1];
        shreg     <= {frame_next[FRAME_W-2:0], 1'b0};
        cnt       <= CNT_W'(FRAME_W-1);
      end else if (cnt != '0) begin
        sdata_out <= shreg[FRAME_W-1];
        shreg     <= {shreg[FRAME_W-2:0], 1'b0};
        cnt       <= cnt - 1'b1;
      end else begin
        sdata_out <= 1'b0;
      end
    end

  p_ack_single_r1: assert property (@(posedge bit_clk) disable iff (!rst_n)
    load_ack |=> !load_ack);
  p_first_bit_ready_r1: assert property (@(posedge bit_clk) disable iff (!rst_n)
    load_ack |-> (sdata_out == $past(codec_ready)));
  p_load_full_count_r2: assert property (@(posedge bit_clk) disable iff (!rst_n)
    load_ack |-> (cnt == CNT_W'(FRAME_W-1)));
  p_count_steps_r2: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (cnt != '0 && !start_pend) |=> (cnt == $past(cnt) - 1'b1));
  p_idle_zero_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (cnt == '0 && !start_pend) |=> !sdata_out);
  p_reset_quiet_r10: assert property (@(posedge bit_clk)
    !rst_n |-> (!sdata_out && !load_ack));
endmodule

// File: tb/acl_infrm_gen_tb.sv
module acl_infrm_gen_tb_top;
  logic         bit_clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sync = 1'b0;
  logic         codec_ready = 1'b0;
  logic [11:0]  slot_tags = '0;
  logic [6:0]   reg_index = '0;
  logic [9:0]   slot_req = '0;
  logic [219:0] slot_data = '0;
  logic         sdata_out, load_ack;
  int checks = 0, fails = 0;

  always #4 bit_clk = ~bit_clk;

  acl_infrm_gen dut_i (.bit_clk, .rst_n, .sync, .codec_ready, .slot_tags,
                       .reg_index, .slot_req, .slot_data, .sdata_out, .load_ack);

  function automatic logic [255:0] model(input logic rdy, input logic [11:0] tg,
      input logic [6:0] ix, input logic [9:0] rq, input logic [219:0] dt);
    logic [255:0] f = '0;
    if (rdy) begin
      f[255] = 1'b1;
      f[254:243] = tg;
      if (tg[11]) f[239:220] = {1'b0, ix, rq, 2'b00};
      for (int s = 2; s <= 12; s++)
        if (tg[12-s]) f[259 - 20*s -: 20] = dt[(s-2)*20 +: 20];
    end
    return f;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_data(input int seed);
    for (int k = 0; k < 11; k++) slot_data[k*20 +: 20] = 20'(seed * 20'h3b1 + k * 20'h1e57 + 20'h80001);
  endtask

  task automatic run_frame(input string req, input bit hold, input bit change_mid);
    logic [255:0] exp, got;
    exp = model(codec_ready, slot_tags, reg_index, slot_req, slot_data);
    got = '0;
    @(posedge bit_clk); #1 sync = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(posedge bit_clk); #2;
      got[255-i] = sdata_out;
      if (i == 0) check(load_ack == 1'b1, {req, " R1 ack high"}, 256'(load_ack), 256'(1));
      if (i == 1) check(load_ack == 1'b0, {req, " R1 ack pulse"}, 256'(load_ack), 256'(0));
      if (i == 15 && !hold) sync = 1'b0;
      if (i == 50 && change_mid) begin
        codec_ready = ~codec_ready; slot_tags = ~slot_tags;
        reg_index = ~reg_index; slot_req = ~slot_req; fill_data(99);
      end
    end
    check(got == exp, {req, " frame"}, got, exp);
  endtask

  task automatic t_reset;
    #2;
    check(sdata_out == 1'b0 && load_ack == 1'b0, "R10 in reset", 256'({sdata_out, load_ack}), 256'(0));
    repeat (3) @(posedge bit_clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge bit_clk); #2;
    check(sdata_out == 1'b0 && load_ack == 1'b0, "R10 after reset", 256'({sdata_out, load_ack}), 256'(0));
  endtask

  task automatic t_full;
    codec_ready = 1'b1; slot_tags = 12'hfff; reg_index = 7'h55; slot_req = 10'h2a5; fill_data(1);
    run_frame("R2 R3 R5 R6 all slots", 1'b0, 1'b0);
  endtask

  task automatic t_not_ready;
    codec_ready = 1'b0; slot_tags = 12'hfff; fill_data(2);
    run_frame("R4 not ready", 1'b0, 1'b0);
  endtask

  task automatic t_sparse;
    codec_ready = 1'b1; slot_tags = 12'b0110_1001_0011; fill_data(3);
    run_frame("R6 R3 sparse tags", 1'b0, 1'b0);
  endtask

  task automatic t_slot1;
    codec_ready = 1'b1; slot_tags = 12'h800; reg_index = 7'h7f; slot_req = 10'b00_1000_0100;
    run_frame("R5 slot1 line bits", 1'b0, 1'b0);
  endtask

  task automatic t_mid_change;
    codec_ready = 1'b1; slot_tags = 12'h5a3; reg_index = 7'h21; slot_req = 10'h0f0; fill_data(4);
    run_frame("R7 mid-frame change", 1'b0, 1'b1);
  endtask

  task automatic t_hold_idle;
    logic [19:0] tail;
    codec_ready = 1'b1; slot_tags = 12'hfff; fill_data(5);
    run_frame("R8 sync held", 1'b1, 1'b0);
    tail = '0;
    for (int i = 0; i < 20; i++) begin
      @(posedge bit_clk); #2;
      tail[i] = sdata_out | load_ack;
    end
    check(tail == '0, "R8 idle zeros", 256'(tail), 256'(0));
    sync = 1'b0;
  endtask

  task automatic t_restart;
    logic [255:0] exp1, exp2, got;
    codec_ready = 1'b1; slot_tags = 12'hfff; reg_index = 7'h12; slot_req = 10'h155; fill_data(6);
    exp1 = model(codec_ready, slot_tags, reg_index, slot_req, slot_data);
    got = '0;
    @(posedge bit_clk); #1 sync = 1'b1;
    for (int i = 0; i < 101; i++) begin
      @(posedge bit_clk); #2;
      got[255-i] = sdata_out;
      if (i == 15) sync = 1'b0;
      if (i == 60) begin slot_tags = 12'h3c3; reg_index = 7'h6e; fill_data(7); end
    end
    check(got[255:155] == exp1[255:155], "R9 first part", got, exp1);
    exp2 = model(codec_ready, slot_tags, reg_index, slot_req, slot_data);
    sync = 1'b1;
    got = '0;
    for (int i = 0; i < 256; i++) begin
      @(posedge bit_clk); #2;
      got[255-i] = sdata_out;
      if (i == 0) check(load_ack == 1'b1, "R9 restart ack", 256'(load_ack), 256'(1));
      if (i == 15) sync = 1'b0;
    end
    check(got == exp2, "R9 restarted frame", got, exp2);
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset;
    t_full;
    t_not_ready;
    t_sparse;
    t_slot1;
    t_mid_change;
    t_hold_idle;
    t_restart;
    repeat (4) @(posedge bit_clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule